// File: doc/BRIEF.md
# Collatz Stopping-Time Iterator Core

This core takes one starting number and walks its trajectory under the shortened Collatz map, one step per clock. An even value is halved. An odd value is tripled, incremented and halved in the same cycle. The walk stops at the first value that is strictly smaller than the start. The core then reports how many steps that took (the stopping time) and the largest value seen on the way (the excursion).

The datapath width is a parameter and defaults to 128 bits, so very large excursions still fit. If a step would not fit in the datapath, the run aborts and the overflow flag is raised. A step limit set by a parameter ends a run that never drops below its start and raises the timeout flag. Such a run marks a candidate that needs a closer look. Each core is self-contained, so many can be placed side by side, with each one fed its own starting numbers.

A start is offered with `start_valid`/`start_value` and is taken only while `start_ready` is high. The result appears with `done_valid` and is held until `done_ack` is seen.

Top module: `collatz_stop_core`

## Requirements
- R1: `start_ready` is high only when the core is idle. A `start_valid` offered while a run is in progress, or while a result is waiting, is ignored and does not change the result.
- R2: When the current value n is even, the next value is n/2.
- R3: When the current value n is odd, the next value is (3n+1)/2, computed in one step.
- R4: The run ends at the first value strictly below the start. `steps` then equals the number of steps taken, and both flags are low.
- R5: `peak` reports the largest value in the trajectory, counting the start value itself.
- R6: If the next value of an odd step does not fit in W bits, the run ends with `overflow`=1 and `timeout`=0. `steps` then counts only the steps completed before that one, and `peak` covers only the values that fit.
- R7: If the count reaches STEP_LIMIT and no value has dropped below the start, the run ends with `timeout`=1 and `steps`=STEP_LIMIT. If the drop happens on exactly the limit step, the run is treated as a normal finish.
- R8: `done_valid`, `steps`, `peak`, `overflow` and `timeout` stay constant while `done_ack` is low. One cycle with `done_ack` high returns the core to idle.
- R9: Reset makes the core idle with `done_valid`, `steps`, `peak` and both flags at zero.
- R10: Suppose a start is accepted at clock edge k and the run ends after s completed steps. Then `done_valid` rises after edge k+s, or after edge k+s+1 when the run ends by overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | A starting number is offered |
| start_value | input | W | Starting number |
| start_ready | output | 1 | Core is idle and takes a start |
| done_valid | output | 1 | Result is available; held until acknowledged |
| done_ack | input | 1 | Consumes the result |
| steps | output | CW | Stopping time, or the step count at abort |
| peak | output | W | Maximum excursion |
| overflow | output | 1 | Run aborted because a value exceeded W bits |
| timeout | output | 1 | Run hit STEP_LIMIT without dropping below its start |

## Verification
Small odd starts such as 3, 7 and 27 mix odd and even steps, which separates the fused odd step from the halving step and tests the peak tracking. An even start finishes after a single halving step, which shows that the comparison is against the start value and not against 1. Starts of 1 and 0 never drop below themselves, so they can only finish by timeout. A second core with a limit of 4 runs start 3, which drops below its start on exactly the limit step, and start 7, which does not. All-ones and 2^127−1 overflow on the first and on the second step, which pins down the abort count and the excursion up to the abort.

// File: rtl/collatz_stop_core.sv
module collatz_stop_core #(
  parameter int W          = 128,
  parameter int CW         = 32,
  parameter int STEP_LIMIT = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  input  logic [W-1:0]  start_value,
  output logic          start_ready,
  output logic          done_valid,
  input  logic          done_ack,
  output logic [CW-1:0] steps,
  output logic [W-1:0]  peak,
  output logic          overflow,
  output logic          timeout
);

  localparam logic [CW-1:0] LIM = CW'(STEP_LIMIT);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;
  state_t state;

  logic [W-1:0] cur, origin;

  wire [W:0]    half    = {2'b00, cur[W-1:1]};
  wire [W:0]    odd_nx  = {1'b0, cur} + half + {{W{1'b0}}, 1'b1};
  wire [W:0]    nx      = cur[0] ? odd_nx : half;
  wire          ovf     = nx[W];
  wire [W-1:0]  nv      = nx[W-1:0];
  wire [CW-1:0] cnt_nx  = steps + 1'b1;
  wire          below   = nv < origin;
  wire          at_lim  = cnt_nx == LIM;

  assign start_ready = state == S_IDLE;
  assign done_valid  = state == S_DONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur      <= '0;
      origin   <= '0;
      steps    <= '0;
      peak     <= '0;
      overflow <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_valid) begin
          state    <= S_RUN;
          cur      <= start_value;
          origin   <= start_value;
          peak     <= start_value;
          steps    <= '0;
          overflow <= 1'b0;
          timeout  <= 1'b0;
        end
        S_RUN: begin
          if (ovf) begin
            overflow <= 1'b1;
            state    <= S_DONE;
          end else begin
            cur   <= nv;
            steps <= cnt_nx;
            if (nv > peak) peak <= nv;
            if (below) state <= S_DONE;
            else if (at_lim) begin
              timeout <= 1'b1;
              state   <= S_DONE;
            end
          end
        end
        S_DONE: if (done_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !done_valid);

  p_busy_ignores_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |=> $stable(origin));

  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && !overflow && !ovf) |=> steps == $past(steps) + 1'b1);

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !overflow && !timeout) |-> cur < origin);

  p_peak_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> peak >= cur);

  p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !(overflow && timeout));

  p_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && timeout) |-> steps == LIM);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ack) |=> done_valid && $stable(steps) && $stable(peak)
                                  && $stable(overflow) && $stable(timeout));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_ack) |=> start_ready);

endmodule

// File: tb/collatz_stop_core_tb.sv
module collatz_stop_core_tb;
  localparam int W  = 128;
  localparam int CW = 32;
  localparam int LIM_A = 500;
  localparam int LIM_B = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic [W-1:0] start_value = '0;
  logic done_ack = 1'b0;

  logic rdy_a, dv_a, ov_a, to_a, rdy_b, dv_b, ov_b, to_b;
  logic [CW-1:0] st_a, st_b;
  logic [W-1:0] pk_a, pk_b;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  collatz_stop_core #(.W(W), .CW(CW), .STEP_LIMIT(LIM_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_value(start_value),
    .start_ready(rdy_a), .done_valid(dv_a), .done_ack(done_ack),
    .steps(st_a), .peak(pk_a), .overflow(ov_a), .timeout(to_a));

  collatz_stop_core #(.W(W), .CW(CW), .STEP_LIMIT(LIM_B)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_value(start_value),
    .start_ready(rdy_b), .done_valid(dv_b), .done_ack(done_ack),
    .steps(st_b), .peak(pk_b), .overflow(ov_b), .timeout(to_b));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [W-1:0] s, input int lim, output int st,
                                output logic [W-1:0] pk, output bit ov, output bit to);
    logic [W+1:0] n, t;
    n = {2'b00, s}; pk = s; st = 0; ov = 0; to = 0;
    forever begin
      if (n[0] == 1'b0) t = n / 2;
      else t = (n * 3 + 1) / 2;
      if (t >= ({{(W+1){1'b0}}, 1'b1} << W)) begin ov = 1; break; end
      st++;
      n = t;
      if (n[W-1:0] > pk) pk = n[W-1:0];
      if (n < {2'b00, s}) break;
      if (st == lim) begin to = 1; break; end
    end
  endfunction

  task automatic run_pair(input logic [W-1:0] s, input string tag);
    int sa, sb, la, lb, lmax;
    logic [W-1:0] pa, pb;
    bit oa, ob, ta, tb;
    model(s, LIM_A, sa, pa, oa, ta);
    model(s, LIM_B, sb, pb, ob, tb);
    la = sa + (oa ? 1 : 0);
    lb = sb + (ob ? 1 : 0);
    lmax = (la > lb) ? la : lb;
    @(negedge clk);
    chk(rdy_a && rdy_b, "R1", {tag, " ready before start"}, {rdy_a, rdy_b}, 2'b11);
    start_valid = 1'b1;
    start_value = s;
    @(negedge clk);
    chk(!rdy_a && !rdy_b, "R1", {tag, " busy after accept"}, {rdy_a, rdy_b}, 0);
    chk(!dv_a && !dv_b, "R10", {tag, " no result at accept"}, {dv_a, dv_b}, 0);
    start_value = ~s;
    for (int i = 1; i <= lmax; i++) begin
      @(negedge clk);
      chk(dv_a == (i >= la), "R10", {tag, " timing big core"}, dv_a, i >= la);
      chk(dv_b == (i >= lb), "R10", {tag, " timing small core"}, dv_b, i >= lb);
      chk(!rdy_a && !rdy_b, "R1", {tag, " ready low while busy"}, {rdy_a, rdy_b}, 0);
      if (i == la) begin
        chk(st_a == CW'(sa), "R4", {tag, " steps big"}, st_a, sa);
        chk(pk_a == pa, "R5", {tag, " peak big"}, pk_a, pa);
        chk(ov_a == oa, "R6", {tag, " overflow big"}, ov_a, oa);
        chk(to_a == ta, "R7", {tag, " timeout big"}, to_a, ta);
      end
      if (i == lb) begin
        chk(st_b == CW'(sb), "R4", {tag, " steps small"}, st_b, sb);
        chk(pk_b == pb, "R5", {tag, " peak small"}, pk_b, pb);
        chk(ov_b == ob, "R6", {tag, " overflow small"}, ov_b, ob);
        chk(to_b == tb, "R7", {tag, " timeout small"}, to_b, tb);
      end
    end
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      chk(dv_a && dv_b, "R8", {tag, " done held"}, {dv_a, dv_b}, 2'b11);
      chk(st_a == CW'(sa) && st_b == CW'(sb), "R8", {tag, " steps held"}, st_a, sa);
      chk(pk_a == pa && pk_b == pb, "R8", {tag, " peak held"}, pk_a, pa);
    end
    start_valid = 1'b0;
    done_ack = 1'b1;
    @(negedge clk);
    done_ack = 1'b0;
    chk(!dv_a && !dv_b, "R8", {tag, " done cleared by ack"}, {dv_a, dv_b}, 0);
    chk(rdy_a && rdy_b, "R8", {tag, " idle after ack"}, {rdy_a, rdy_b}, 2'b11);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy_a && !dv_a && st_a == 0 && pk_a == 0 && !ov_a && !to_a, "R9",
        "reset state", {rdy_a, dv_a, ov_a, to_a}, 4'b1000);
    rst_n = 1'b1;

    run_pair(128'd3, "R3 start 3 hits limit step exactly (R7)");
    run_pair(128'd7, "R3 start 7");
    run_pair(128'd27, "R2 R3 start 27");
    run_pair(128'd10, "R2 even start 10");
    run_pair(128'd1, "R7 start 1");
    run_pair(128'd0, "R7 start 0");
    run_pair({W{1'b1}}, "R6 all ones");
    run_pair({1'b0, {(W-1){1'b1}}}, "R6 overflow second step");
    run_pair({1'b1, {(W-2){1'b0}}, 1'b1}, "R3 wide odd start");

    @(negedge clk);
    start_valid = 1'b1;
    start_value = 128'd27;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(rdy_a && !dv_a && st_a == 0 && pk_a == 0 && !ov_a && !to_a, "R9",
        "mid-run reset", {rdy_a, dv_a, ov_a, to_a}, 4'b1000);
    run_pair(128'd9, "R9 run after reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule